// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block connects the signal slots of ten on-chip digital functions to a bank of up to 32 general-purpose pins, arranged as 8-pin ports. A small register bank holds a switch for each function, plus a 3-bit count for the capture/compare unit. Switched-on functions are placed one after another in a fixed rank order, starting from the lowest pin. A function that is switched off takes no pins, so enabling or disabling one function moves every function ranked below it. Any pin that no function claims acts as a plain GPIO output, driven from that port's latch register.

Each pin also has a drive-mode bit. Push-pull mode drives both levels. Open-drain mode drives only a low level and releases the pin for a high level. Function inputs are taken from the pin the function currently occupies. The live level of any port can be read back at any time. A build parameter selects three or four ports.

Function slots, in rank order, with their slot indices on `fn_*`: serial channel A (2, slots 0-1), synchronous serial (4, slots 2-5), two-wire bus (2, slots 6-7), serial channel B (2, slots 8-9), capture/compare (0 to 6, slots 10-15), comparator outputs (2, slots 16-17), timer/interrupt group (8, slots 18-25), second timer group (6, slots 26-31), clock output (1, slot 32), conversion-start input (1, slot 33).

Top module: `pin_crossbar`

## Requirements
- R1: After reset, all latch bits are 1, all pins are open-drain and all functions are off. Every `pad_oe` bit is 0, every `pad_out` bit is 0, `alloc_overflow` is 0 and every `fn_in` bit is 1.
- R2: Switched-on functions occupy consecutive pins in rank order, starting at pin 0. The lowest slot of a function goes to its lowest pin. Functions that are off use no pins.
- R3: The capture/compare unit takes as many pins as the count in register 1 bits [2:0]. Counts of 7 are treated as 6.
- R4: A function whose pins would run past the last available pin gets no pins, and `alloc_overflow` goes high. With exactly enough pins, the flag stays low.
- R5: An unclaimed pin is driven from the latch bit of its port.
- R6: With the mode bit at 0 (open-drain), a pin drives only a low level: `pad_oe` = source output-enable AND NOT source value, and `pad_out` = 0.
- R7: With the mode bit at 1 (push-pull), `pad_oe` follows the source output-enable and `pad_out` follows the source value. The source is the owning function or, for an unclaimed pin, the latch with output-enable 1.
- R8: `fn_in[s]` equals the level on the pin that slot s occupies. A slot that holds no pin reads 1.
- R9: `rd_data` returns `pad_in` bits [8*rd_port+7 : 8*rd_port] whether or not a function owns those pins. For a port not present, it returns 0xFF.
- R10: Writes apply on the clock edge while `wr_en` is high. Address 0 bits [3:0] switch functions 0 to 3. Address 1 bits [2:0] hold the capture/compare count. Address 2 bit 0 switches the comparator outputs and bit 1 the timer group. Address 3 bits [2:0] switch the second timer group, clock output and conversion start. Addresses 4 to 7 hold the port latches. Addresses 8 to 11 hold the port mode bits.
- R11: When built with three ports, the capacity is 24 pins, and pins 24 to 31 are never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| fn_out | input | 34 | Output value of each function slot |
| fn_oe | input | 34 | Output enable of each function slot |
| fn_in | output | 34 | Pin level delivered to each function slot |
| pad_in | input | 32 | Live pin levels |
| pad_out | output | 32 | Pin drive value |
| pad_oe | output | 32 | Pin output enable |
| rd_port | input | 2 | Port selected for readback |
| rd_data | output | 8 | Live levels of the selected port |
| alloc_overflow | output | 1 | Some enabled function did not fit |

## Verification
The hardest state to reach is the pin budget's edge. The bench switches on every function with the full capture/compare count, which asks for 34 pins. It then checks that the last two functions fall off while the slot just before them still lands on pin 31. It then drops only the top-ranked function and shows that the rest fit exactly, with no flag. A second instance built with three ports receives the same writes, so the same configuration overflows much earlier there, and its upper port stays undriven.

// File: rtl/pin_crossbar.sv
module pin_crossbar #(
  parameter int NUM_PORTS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [33:0] fn_out,
  input  logic [33:0] fn_oe,
  output logic [33:0] fn_in,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe,
  input  logic [1:0]  rd_port,
  output logic [7:0]  rd_data,
  output logic        alloc_overflow
);
  localparam int NPINS = 8 * NUM_PORTS;
  localparam int NGRP  = 10;
  localparam int NSLOT = 34;

  function automatic int grp_width(int g);
    case (g)
      0: return 2;
      1: return 4;
      2: return 2;
      3: return 2;
      4: return 6;
      5: return 2;
      6: return 8;
      7: return 6;
      default: return 1;
    endcase
  endfunction

  function automatic int grp_first(int g);
    int a = 0;
    for (int i = 0; i < g; i++) a += grp_width(i);
    return a;
  endfunction

  function automatic int slot_grp(int s);
    int r = 0;
    for (int g = 1; g < NGRP; g++) if (s >= grp_first(g)) r = g;
    return r;
  endfunction

  logic [3:0] en_lo;
  logic [2:0] cc_cnt;
  logic [1:0] en_mid;
  logic [2:0] en_hi;
  logic [7:0] latch [4];
  logic [7:0] mode  [4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lo  <= '0;
      cc_cnt <= '0;
      en_mid <= '0;
      en_hi  <= '0;
      for (int i = 0; i < 4; i++) begin
        latch[i] <= 8'hFF;
        mode[i]  <= 8'h00;
      end
    end else if (wr_en) begin
      case (wr_addr[3:2])
        2'd0: case (wr_addr[1:0])
          2'd0: en_lo  <= wr_data[3:0];
          2'd1: cc_cnt <= wr_data[2:0];
          2'd2: en_mid <= wr_data[1:0];
          default: en_hi <= wr_data[2:0];
        endcase
        2'd1: latch[wr_addr[1:0]] <= wr_data;
        2'd2: mode[wr_addr[1:0]]  <= wr_data;
        default: ;
      endcase
    end
  end

  logic [31:0] latch_f, mode_f;
  assign latch_f = {latch[3], latch[2], latch[1], latch[0]};
  assign mode_f  = {mode[3], mode[2], mode[1], mode[0]};

  logic [3:0]      gw   [NGRP];
  logic [6:0]      base [NGRP];
  logic [NGRP-1:0] fits;
  logic [NGRP-1:0] lost;

  always_comb begin
    logic [6:0] acc;
    gw[0] = en_lo[0]  ? 4'd2 : 4'd0;
    gw[1] = en_lo[1]  ? 4'd4 : 4'd0;
    gw[2] = en_lo[2]  ? 4'd2 : 4'd0;
    gw[3] = en_lo[3]  ? 4'd2 : 4'd0;
    gw[4] = (cc_cnt > 3'd6) ? 4'd6 : {1'b0, cc_cnt};
    gw[5] = en_mid[0] ? 4'd2 : 4'd0;
    gw[6] = en_mid[1] ? 4'd8 : 4'd0;
    gw[7] = en_hi[0]  ? 4'd6 : 4'd0;
    gw[8] = en_hi[1]  ? 4'd1 : 4'd0;
    gw[9] = en_hi[2]  ? 4'd1 : 4'd0;
    acc = '0;
    for (int g = 0; g < NGRP; g++) begin
      base[g] = acc;
      fits[g] = (acc + 7'(gw[g])) <= 7'(NPINS);
      lost[g] = (gw[g] != 4'd0) && !fits[g];
      acc     = acc + 7'(gw[g]);
    end
  end

  assign alloc_overflow = |lost;

  logic [NSLOT-1:0] act;
  logic [6:0]       spin [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int G   = slot_grp(s);
    localparam int OFF = s - grp_first(G);
    assign act[s]   = fits[G] && (4'(OFF) < gw[G]);
    assign spin[s]  = base[G] + 7'(OFF);
    assign fn_in[s] = act[s] ? pad_in[spin[s][4:0]] : 1'b1;
  end

  for (genvar p = 0; p < 32; p++) begin : g_pin
    if (p < NPINS) begin : g_live
      logic dv, doe;
      always_comb begin
        dv  = latch_f[p];
        doe = 1'b1;
        for (int s = 0; s < NSLOT; s++) begin
          if (act[s] && spin[s] == 7'(p)) begin
            dv  = fn_out[s];
            doe = fn_oe[s];
          end
        end
      end
      assign pad_oe[p]  = mode_f[p] ? doe : (doe & ~dv);
      assign pad_out[p] = mode_f[p] & dv;
    end else begin : g_absent
      assign pad_oe[p]  = 1'b0;
      assign pad_out[p] = 1'b0;
    end
  end

  assign rd_data = (32'(rd_port) < NUM_PORTS) ? pad_in[{rd_port, 3'b000} +: 8] : 8'hFF;

  // R10: a write to address 0 lands in the function switches
  p_cfg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd0) |=> (en_lo == $past(wr_data[3:0])));

  // R2: the top-ranked function always starts at pin 0
  p_first_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_lo[0] |-> (pad_oe[0] == (mode_f[0] ? fn_oe[0] : (fn_oe[0] & ~fn_out[0]))));

  // R4: when something overflows, an enabled last-ranked input is cut off
  p_overflow_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_overflow && en_hi[2]) |-> fn_in[33]);

  // R6: an idle open-drain pin 0 releases for a high latch bit
  p_od_gpio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_f[0] && en_lo == 4'd0 && cc_cnt == 3'd0 && en_mid == 2'd0 && en_hi == 3'd0)
      |-> (pad_oe[0] == !latch_f[0] && !pad_out[0]));

  if (NUM_PORTS < 4) begin : g_chk_absent
    // R11: an absent port is never driven
    p_absent_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[31:24] == 8'h00);
  end
endmodule

// File: tb/pin_crossbar_test.sv
module pin_crossbar_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [33:0] fn_out = '0;
  logic [33:0] fn_oe = '0;
  logic [31:0] pad_in = '0;
  logic [1:0]  rd_port = '0;
  logic [33:0] fn_in, fn_in3;
  logic [31:0] pad_out, pad_oe, pad_out3, pad_oe3;
  logic [7:0]  rd_data, rd_data3;
  logic        ovf, ovf3;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pin_crossbar uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .rd_port(rd_port), .rd_data(rd_data),
    .alloc_overflow(ovf));

  pin_crossbar #(.NUM_PORTS(3)) uut3 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in3), .pad_in(pad_in),
    .pad_out(pad_out3), .pad_oe(pad_oe3), .rd_port(rd_port), .rd_data(rd_data3),
    .alloc_overflow(ovf3));

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 pad_oe", 64'(pad_oe), 64'h0);
    chk("R1 pad_out", 64'(pad_out), 64'h0);
    chk("R1 overflow", 64'(ovf), 64'h0);
    chk("R1 fn_in idle", 64'(fn_in), 64'h3_FFFF_FFFF);
    chk("R11 reset overflow", 64'(ovf3), 64'h0);
  endtask

  task automatic t_gpio;
    wr(4'd4, 8'hA5);
    wr(4'd8, 8'hFF);
    wr(4'd5, 8'h0F);
    chk("R5 R7 R10 push-pull latch out", 64'(pad_out[7:0]), 64'hA5);
    chk("R7 push-pull oe", 64'(pad_oe[7:0]), 64'hFF);
    chk("R6 open-drain oe", 64'(pad_oe[15:8]), 64'hF0);
    chk("R6 open-drain out", 64'(pad_out[15:8]), 64'h00);
  endtask

  task automatic t_priority;
    fn_oe = '1;
    fn_out = 34'h3C;
    pad_in = 32'h1234_5678;
    wr(4'd0, 8'h02);
    chk("R2 sync serial alone at pin 0", 64'(pad_out[7:0]), 64'hAF);
    wr(4'd0, 8'h03);
    chk("R2 sync serial shifted", 64'(pad_out[7:0]), 64'hBC);
    chk("R8 inputs from shifted pins", 64'(fn_in[5:2]), 64'hE);
    chk("R8 off slots read 1", 64'(fn_in[9:6]), 64'hF);
    rd_port = 2'd0;
    #1;
    chk("R9 readback owned port", 64'(rd_data), 64'h78);
    rd_port = 2'd1;
    #1;
    chk("R9 readback port 1", 64'(rd_data), 64'h56);
    rd_port = 2'd3;
    #1;
    chk("R9 absent port reads FF", 64'(rd_data3), 64'hFF);
  endtask

  task automatic t_count;
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h07);
    wr(4'd2, 8'h01);
    chk("R3 count 7 clamps to 6", 64'(fn_in[15:10]), 64'h38);
    chk("R3 comparator after 6 pins", 64'(fn_in[17:16]), 64'h1);
    wr(4'd1, 8'h03);
    chk("R3 count 3 pins", 64'(fn_in[15:10]), 64'h38);
    chk("R3 comparator after 3 pins", 64'(fn_in[17:16]), 64'h3);
  endtask

  task automatic t_overflow;
    pad_in = 32'h0;
    for (int a = 8; a < 12; a++) wr(4'(a), 8'hFF);
    wr(4'd0, 8'h0F);
    wr(4'd1, 8'h06);
    wr(4'd2, 8'h03);
    wr(4'd3, 8'h07);
    chk("R4 overflow raised", 64'(ovf), 64'h1);
    chk("R4 lost functions read 1", 64'(fn_in[33:32]), 64'h3);
    chk("R4 last fitting slot on pin 31", 64'(fn_in[31]), 64'h0);
    chk("R11 three-port overflow", 64'(ovf3), 64'h1);
    chk("R11 absent port undriven", 64'(pad_oe3[31:24]), 64'h00);
    wr(4'd0, 8'h0E);
    chk("R4 exact fit no flag", 64'(ovf), 64'h0);
    chk("R4 exact fit connects tail", 64'(fn_in[33:32]), 64'h0);
    chk("R11 still overflows at 24 pins", 64'(ovf3), 64'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_gpio;
    t_priority;
    t_count;
    t_overflow;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule